// File: doc/BRIEF.md
# Dual-Clause MDIO Management Master

This block lets a processor reach the management registers of Ethernet PHYs over the two-wire MDC/MDIO bus. Software writes a few word-addressed registers, then sets the launch bit. The block then shifts one complete management frame onto the bus and clears its busy flag when the frame is finished. Both frame styles come from one operation register. In the single-frame legacy style (Clause 22), the register number travels inside the frame. In the indirect style (Clause 45), software first sends an address frame and then a separate read or write frame. Software sequences these two frames itself.

Each frame is 64 bit times long. It starts with 32 ones, followed by the start and opcode bits, the port and device fields, a two-bit turnaround and a 16-bit payload, all sent MSB first. The payload comes from the address register for an indirect address frame and from the data register otherwise. On a read, the block releases the data line from the turnaround onward and samples the PHY's answer on each rising MDC edge. It stores the 16 answer bits in the data register when the frame ends. The MDIO pin is split into output, output-enable and input so that the pad can sit outside the block.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, MDC is low, MDIO is released (`mdioOe` low, `mdioOut` low), and the data, address, operation and control registers all read 0.
- R2: Word offsets are 4 = data (bits 15:0), 5 = address (bits 15:0), 6 = operation (bits 12:0), 7 = control (bit 0 = busy). Unused upper bits read 0, and every other offset reads 0.
- R3: The operation register holds bit 12 = clause select (1 = indirect/Clause 45, 0 = legacy/Clause 22), bits 11:10 = the opcode as sent on the wire, bits 9:5 = port address and bits 4:0 = device number or register number.
- R4: Writing 1 to control bit 0 while idle launches one frame. Control bit 0 reads 1 from the next cycle for 64 MDC periods. Each MDC period is low for HALF and high for HALF clock cycles, with HALF = ceil(SYS_CLK_HZ / (2*MDC_MAX_HZ)). MDC idles low.
- R5: A frame is sent MSB first as 32 ones, start bits (00 for Clause 45, 01 for Clause 22), 2 opcode bits, 5 port bits, 5 device/register bits, turnaround 10, and 16 payload bits. The payload is the address register when the clause is 45 and the opcode is 00, and the data register otherwise.
- R6: A frame whose opcode MSB is 1 (Clause 45 read 11, Clause 22 read 10) releases MDIO from bit 46 (the turnaround) to the end. The block samples MDIO on each rising MDC edge, and at frame end the data register holds the last 16 sampled bits.
- R7: While a frame is in progress, writes to the data, address and operation registers and further launch writes have no effect.
- R8: MDIO output and output enable change only together with a falling MDC edge during a frame. A frame starts with MDIO driven to 1.
- R9: Whenever MDIO is released, `mdioOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register word offset |
| busWr | input | 1 | Register write strobe |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for `busAddr` (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value to drive |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value at the pad |

## Verification
A bad bit counter or divider value changes the MDC waveform, the MDIO bit sequence or the release point. The bench compares all three on every clock against its own model of the frame, so such an error shows up within one MDC half period. A bad capture shift or latch condition leaves the data register wrong after a read, and the bench catches this on the first readback after that frame. Register gating faults show either as a restarted frame or as changed readback values after the frame, within the same transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_ADDR_W  = 4;
  localparam logic [REG_ADDR_W-1:0] OFS_DATA = 4'd4;
  localparam logic [REG_ADDR_W-1:0] OFS_ADDR = 4'd5;
  localparam logic [REG_ADDR_W-1:0] OFS_OP   = 4'd6;
  localparam logic [REG_ADDR_W-1:0] OFS_CTRL = 4'd7;

  localparam int PREAMBLE_LEN = 32;
  localparam int FIELD_W      = 5;
  localparam int PAYLOAD_W    = 16;
  localparam int OP_W         = 2*FIELD_W + 3;
  localparam int FRAME_BITS   = PREAMBLE_LEN + 4 + 2*FIELD_W + 2 + PAYLOAD_W;
  localparam int BIT_CNT_W    = $clog2(FRAME_BITS);
  localparam int TA_BIT       = PREAMBLE_LEN + 4 + 2*FIELD_W;

  // operation register field positions
  localparam int OP_CLAUSE_BIT = 2*FIELD_W + 2;
  localparam int OP_CODE_HI    = 2*FIELD_W + 1;

  typedef struct packed {
    logic load;    // capture new frame into the shifter
    logic sample;  // MDC about to rise: capture MDIO
    logic shift;   // MDC about to fall: present next bit
    logic done;    // final falling edge of the frame
  } mdioStrobeT;
endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       launchReq,
  input  logic       frameIsRead,
  output mdioStrobeT strobe,
  output logic       busy,
  output logic       mdc,
  output logic       mdioOe
);
  localparam int DIV_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYCLES - 1);
  localparam logic [BIT_CNT_W-1:0] BIT_LAST = BIT_CNT_W'(FRAME_BITS - 1);
  localparam logic [BIT_CNT_W-1:0] BIT_TA   = BIT_CNT_W'(TA_BIT);

  logic [DIV_W-1:0]     divCnt;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic                 tick;
  logic                 lastBit;

  assign tick    = busy && (divCnt == DIV_LAST);
  assign lastBit = (bitCnt == BIT_LAST);

  always_comb begin
    strobe.load   = launchReq && !busy;
    strobe.sample = tick && !mdc;
    strobe.shift  = tick && mdc && !lastBit;
    strobe.done   = tick && mdc && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
        end else begin
          mdc <= 1'b0;
          if (lastBit) busy <= 1'b0;
          else         bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdioOe = busy && !(frameIsRead && (bitCnt >= BIT_TA));
endmodule

// File: rtl/mdio_regs_dp.sv
module mdio_regs_dp
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWr,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic                  busy,
  input  mdioStrobeT            strobe,
  input  logic                  mdioIn,
  output logic                  shiftBit,
  output logic                  frameIsRead,
  output logic [OP_W-1:0]       opVal
);
  logic [PAYLOAD_W-1:0]  dataQ;
  logic [PAYLOAD_W-1:0]  addrQ;
  logic [OP_W-1:0]       opQ;
  logic [FRAME_BITS-1:0] frameSh;
  logic [PAYLOAD_W-1:0]  capSh;
  logic [FRAME_BITS-1:0] frameWord;
  logic                  isExt;
  logic [1:0]            opCode;

  assign isExt       = opQ[OP_CLAUSE_BIT];
  assign opCode      = opQ[OP_CODE_HI -: 2];
  assign frameIsRead = opCode[1];
  assign opVal       = opQ;
  assign shiftBit    = frameSh[FRAME_BITS-1];

  always_comb begin
    frameWord = {{PREAMBLE_LEN{1'b1}},
                 (isExt ? 2'b00 : 2'b01),
                 opCode,
                 opQ[2*FIELD_W-1:0],
                 2'b10,
                 ((isExt && opCode == 2'b00) ? addrQ : dataQ)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ   <= '0;
      addrQ   <= '0;
      opQ     <= '0;
      frameSh <= '0;
      capSh   <= '0;
    end else begin
      if (busWr && !busy) begin
        unique case (busAddr)
          OFS_DATA: dataQ <= busWdata[PAYLOAD_W-1:0];
          OFS_ADDR: addrQ <= busWdata[PAYLOAD_W-1:0];
          OFS_OP:   opQ   <= busWdata[OP_W-1:0];
          default:  ;
        endcase
      end
      if (strobe.load)       frameSh <= frameWord;
      else if (strobe.shift) frameSh <= {frameSh[FRAME_BITS-2:0], 1'b0};
      if (strobe.sample) capSh <= {capSh[PAYLOAD_W-2:0], mdioIn};
      if (strobe.done && frameIsRead) dataQ <= capSh;
    end
  end

  always_comb begin
    unique case (busAddr)
      OFS_DATA: busRdata = 32'(dataQ);
      OFS_ADDR: busRdata = 32'(addrQ);
      OFS_OP:   busRdata = 32'(opQ);
      OFS_CTRL: busRdata = {31'b0, busy};
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int MDC_MAX_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  busAddr,
  input  logic        busWr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int HALF_RAW    = (SYS_CLK_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ);
  localparam int HALF_CYCLES = (HALF_RAW < 1) ? 1 : HALF_RAW;

  mdioStrobeT       strobe;
  logic             busy;
  logic             frameIsRead;
  logic             shiftBit;
  logic             launchReq;
  logic [OP_W-1:0]  opVal;
  logic [15:0]      halfLen;

  assign launchReq = busWr && (busAddr == OFS_CTRL) && busWdata[0];
  assign halfLen   = 16'(HALF_CYCLES);
  assign mdioOut   = mdioOe && shiftBit;

  mdio_frame_ctrl #(.HALF_CYCLES(HALF_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .launchReq   (launchReq),
    .frameIsRead (frameIsRead),
    .strobe      (strobe),
    .busy        (busy),
    .mdc         (mdc),
    .mdioOe      (mdioOe)
  );

  mdio_regs_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWr       (busWr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .busy        (busy),
    .strobe      (strobe),
    .mdioIn      (mdioIn),
    .shiftBit    (shiftBit),
    .frameIsRead (frameIsRead),
    .opVal       (opVal)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        mdc,
  input logic        mdioOe,
  input logic        mdioOut,
  input logic        busWr,
  input logic [3:0]  busAddr,
  input logic [12:0] opVal,
  input logic [15:0] halfLen
);
  logic        prevMdc;
  logic [15:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMdc <= 1'b0;
      runLen  <= 16'd0;
    end else begin
      prevMdc <= mdc;
      runLen  <= (mdc != prevMdc) ? 16'd1 : runLen + 16'd1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  a_r4_mdc_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);

  a_r4_high_half: assert property (@(posedge clk) disable iff (!rstN)
    (!mdc && prevMdc) |-> (runLen == halfLen));

  a_r8_drive_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (!$stable(mdioOut) || !$stable(mdioOe))) |-> $fell(mdc));

  a_r8_frame_starts_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (mdioOe && mdioOut));

  a_r9_released_low: assert property (@(posedge clk) disable iff (!rstN)
    !mdioOe |-> !mdioOut);

  a_r7_op_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busWr && busAddr == 4'd6) |=> $stable(opVal));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .mdc     (mdc),
  .mdioOe  (mdioOe),
  .mdioOut (mdioOut),
  .busWr   (busWr),
  .busAddr (busAddr),
  .opVal   (opVal),
  .halfLen (halfLen)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam int H      = 10;          // 50 MHz / (2 * 2.5 MHz)
  localparam int FR_CYC = 64 * 2 * H;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = 4'd0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int vecs = 0;
  int errs = 0;

  always #10 clk = ~clk;

  mdio_mgmt_master uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    chk(tag, busRdata, exp);
    @(negedge clk);
  endtask

  function automatic logic [12:0] mkOp(input bit ext, input logic [1:0] oc,
                                       input logic [4:0] port, input logic [4:0] dev);
    return {ext, oc, port, dev};
  endfunction

  function automatic logic [63:0] mkFrame(input bit ext, input logic [1:0] oc,
      input logic [4:0] port, input logic [4:0] dev, input logic [15:0] fld);
    return {32'hFFFF_FFFF, (ext ? 2'b00 : 2'b01), oc, port, dev, 2'b10, fld};
  endfunction

  // Launch one frame and compare the pins on every clock against the model.
  task automatic runFrame(input logic [63:0] fr, input bit isRd,
                          input logic [15:0] reply, input bit poke);
    wr(4'd7, 32'd1);
    busAddr = 4'd7;
    for (int k = 0; k < FR_CYC; k++) begin
      int bi;
      bit hi, eOe;
      bi  = k / (2*H);
      hi  = (k % (2*H)) >= H;
      eOe = !(isRd && bi >= 46);
      if (isRd && bi >= 48)      mdioIn = reply[63 - bi];
      else if (isRd && bi == 47) mdioIn = 1'b0;
      else                       mdioIn = 1'b1;
      if (poke) begin
        if (k == 100) begin busAddr = 4'd4; busWdata = 32'h0000_5A5A; busWr = 1'b1; end
        if (k == 101) begin busAddr = 4'd6; busWdata = 32'hFFFF_FFFF; end
        if (k == 102) begin busAddr = 4'd5; busWdata = 32'h0000_7777; end
        if (k == 103) begin busAddr = 4'd7; busWdata = 32'd1; end   // R7 relaunch attempt
        if (k == 104) begin busWr = 1'b0; end
      end
      #1;
      chk("R4 mdc", {31'b0, mdc}, {31'b0, hi});
      chk("R6 mdioOe", {31'b0, mdioOe}, {31'b0, eOe});
      chk("R5 mdioOut", {31'b0, mdioOut}, {31'b0, (eOe ? fr[63 - bi] : 1'b0)});
      if (busAddr == 4'd7) chk("R4 busy", busRdata, 32'd1);
      @(negedge clk);
    end
    mdioIn = 1'b1;
    busAddr = 4'd7;
    #1;
    chk("R4 busy clear", busRdata, 32'd0);
    chk("R4 mdc idle", {31'b0, mdc}, 32'd0);
    chk("R9 released", {30'b0, mdioOe, mdioOut}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 mdc", {31'b0, mdc}, 32'd0);
    chk("R1 mdio", {30'b0, mdioOe, mdioOut}, 32'd0);
    @(negedge clk);
    rdChk("R1 data", 4'd4, 32'd0);
    rdChk("R1 addr", 4'd5, 32'd0);
    rdChk("R1 op", 4'd6, 32'd0);
    rdChk("R1 ctrl", 4'd7, 32'd0);

    // R2 / R3 register map and widths
    wr(4'd4, 32'hFFFF_ABCD); rdChk("R2 data", 4'd4, 32'h0000_ABCD);
    wr(4'd5, 32'h1234_5678); rdChk("R2 addr", 4'd5, 32'h0000_5678);
    wr(4'd6, 32'hFFFF_FFFF); rdChk("R3 op width", 4'd6, 32'h0000_1FFF);
    wr(4'd0, 32'hFFFF_FFFF); rdChk("R2 unused", 4'd0, 32'd0);
    rdChk("R2 offset 8", 4'd8, 32'd0);

    // Clause 45 address frame with writes during the frame (R7)
    wr(4'd4, 32'h1111);
    wr(4'd5, 32'h9002);
    wr(4'd6, 32'(mkOp(1'b1, 2'b00, 5'h03, 5'h01)));
    runFrame(mkFrame(1'b1, 2'b00, 5'h03, 5'h01, 16'h9002), 1'b0, 16'h0, 1'b1);
    rdChk("R7 data kept", 4'd4, 32'h1111);
    rdChk("R7 addr kept", 4'd5, 32'h9002);
    rdChk("R7 op kept", 4'd6, 32'(mkOp(1'b1, 2'b00, 5'h03, 5'h01)));

    // Clause 45 write
    wr(4'd4, 32'hBEEF);
    wr(4'd6, 32'(mkOp(1'b1, 2'b01, 5'h03, 5'h01)));
    runFrame(mkFrame(1'b1, 2'b01, 5'h03, 5'h01, 16'hBEEF), 1'b0, 16'h0, 1'b0);

    // Clause 45 read
    wr(4'd6, 32'(mkOp(1'b1, 2'b11, 5'h03, 5'h01)));
    runFrame(mkFrame(1'b1, 2'b11, 5'h03, 5'h01, 16'hBEEF), 1'b1, 16'hA5C3, 1'b0);
    rdChk("R6 c45 read data", 4'd4, 32'h0000_A5C3);

    // Clause 22 write (start bits 01)
    wr(4'd4, 32'h0140);
    wr(4'd6, 32'(mkOp(1'b0, 2'b01, 5'h1F, 5'h00)));
    runFrame(mkFrame(1'b0, 2'b01, 5'h1F, 5'h00, 16'h0140), 1'b0, 16'h0, 1'b0);

    // Clause 22 read
    wr(4'd6, 32'(mkOp(1'b0, 2'b10, 5'h00, 5'h01)));
    runFrame(mkFrame(1'b0, 2'b10, 5'h00, 5'h01, 16'h0140), 1'b1, 16'h7FFE, 1'b0);
    rdChk("R6 c22 read data", 4'd4, 32'h0000_7FFE);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule